// File: doc/BRIEF.md
# Smart card slot activation sequencer

This block powers up a single ISO 7816 card slot under control of a small register interface. Software writes a non-zero supply-voltage code. The block then turns on the slot supply and waits for the converter to report that the supply is good. After that it lets software apply the card I/O level, gate the card clock and open the I/O path. Card reset is driven in one of two ways. In manual mode it follows a control bit. In automatic mode the block holds reset low for a set number of running clock periods, releases it, and times the falling edge that opens the answer-to-reset.

An activation request is accepted only when the slot's gate input is high and every sticky status flag is clear. For a slot with a presence switch the gate is card presence. For a slot without one it is the shared converter-ready input. If the card is pulled out of an active slot, the block powers down in a fixed order and records the removal. Reading the status register returns the flags and clears them. The interrupt output is high while any flag is set.

Top module: `card_act_seq`

## Requirements
- R1: After reset, vcc_en_o, vcc_sel_o, clk_en_o, rst_o, io_en_o, io_lvl_o and irq_o are all low.
- R2: Writing address 0 with a non-zero code in wdata_i[1:0] while idle, with the gate high and no flag set, raises vcc_en_o and sets vcc_sel_o to that code from the next cycle. The gate is card_present_i when HAS_DETECT=1 and dcdc_ok_i when HAS_DETECT=0. The code then stays fixed until power-down.
- R3: Such a write is ignored, leaving vcc_en_o low, if the gate is low or any status flag is set.
- R4: While the block waits for supply_ok_i, clk_en_o, rst_o, io_en_o and io_lvl_o stay low. When supply_ok_i is high, status bit 0 (ready) is set and irq_o goes high.
- R5: Once the slot is active, clk_en_o is the inverse of control bit 3 (clock stop), io_en_o is the inverse of bit 4 (I/O disable) and io_lvl_o equals bit 2. Each takes effect the cycle after the write.
- R6: With control bit 6 (auto reset) at 0, rst_o equals control bit 5 while the slot is active.
- R7: With bit 6 at 1, rst_o stays low for RST_HOLD cycles of running card clock after activation and then goes high.
- R8: In auto mode, a falling edge on io_i seen m running cycles after rst_o rises gives no error if ATR_MIN <= m <= ATR_MAX. It sets status bit 1 (ATR error) if m < ATR_MIN or if ATR_MAX < m < MUTE_CYC.
- R9: In auto mode, if no falling edge is seen within MUTE_CYC running cycles after rst_o rises, status bit 2 (mute card) is set.
- R10: A read of address 1 returns the flags {removed, mute, ATR error, ready} in rdata_o[3:0] one cycle later and clears them. irq_o is the OR of the flags.
- R11: If the gate drops while the slot is active, rst_o goes low first, then clk_en_o, then io_en_o and io_lvl_o, then vcc_en_o, one step per cycle, and status bit 3 (removed) is set. A write of code 0 follows the same order but sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one card clock period per cycle while the clock runs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| card_present_i | input | 1 | Card presence switch |
| dcdc_ok_i | input | 1 | Shared converter started |
| supply_ok_i | input | 1 | Slot supply within range |
| io_i | input | 1 | Card I/O line level |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address: 0 control, 1 status |
| wdata_i | input | 7 | Write data |
| rdata_o | output | 7 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Any status flag set |
| vcc_en_o | output | 1 | Slot supply enable |
| vcc_sel_o | output | 2 | Supply voltage code |
| clk_en_o | output | 1 | Card clock gate |
| rst_o | output | 1 | Card reset line |
| io_en_o | output | 1 | I/O transparent path enable |
| io_lvl_o | output | 1 | Level applied to the card I/O line |

## Verification
The bench builds the block with HAS_DETECT=1, RST_HOLD=20, ATR_MIN=8, ATR_MAX=60 and MUTE_CYC=100. With these short windows the bench can time the full reset hold and move the start-bit edge to each side of both window limits in a few hundred cycles. It can also wait out the mute timeout. The presence-gated path, the ordered power-down on card removal and flag blocking are all reachable with these values.

// File: rtl/card_act_pkg.sv
package card_act_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_PWR, ST_ACT, ST_D_RST, ST_D_CLK, ST_D_IO} act_st_e;
  typedef enum logic [1:0] {PH_HOLD, PH_WATCH, PH_DONE} atr_ph_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;

  // control bits [6:2]
  typedef struct packed {
    logic auto_rst;
    logic rst_sw;
    logic io_dis;
    logic clk_stop;
    logic io_set;
  } ctrl_t;

  typedef struct packed {
    logic removed;
    logic mute;
    logic atr_err;
    logic ready;
  } flags_t;
endpackage

// File: rtl/card_act_regs.sv
module card_act_regs
  import card_act_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  logic [4:0] wfield_i,
  input  logic [1:0] vcode_i,
  input  flags_t     set_i,
  output ctrl_t      ctrl_o,
  output flags_t     flags_o,
  output logic [6:0] rdata_o
);
  ctrl_t  ctrl_q;
  flags_t flags_q;
  logic   rd_stat;

  assign rd_stat = rd_en_i && (addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      flags_q <= '0;
      rdata_o <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wfield_i);
      // a set in the same cycle as the read survives
      flags_q <= (rd_stat ? flags_t'('0) : flags_q) | set_i;
      if (rd_en_i) begin
        case (addr_i)
          ADDR_CTRL: rdata_o <= {ctrl_q, vcode_i};
          ADDR_STAT: rdata_o <= {3'b000, flags_q};
          default:   rdata_o <= '0;
        endcase
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/card_act_fsm.sv
module card_act_fsm
  import card_act_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ctrl_i,
  input  logic [1:0] wcode_i,
  input  logic       gate_i,
  input  logic       supply_ok_i,
  input  logic       flags_any_i,
  input  ctrl_t      ctrl_i,
  input  logic       rst_auto_i,
  output act_st_e    state_o,
  output logic [1:0] vcode_o,
  output logic       set_ready_o,
  output logic       set_removed_o,
  output logic       vcc_en_o,
  output logic       clk_en_o,
  output logic       rst_o,
  output logic       io_en_o,
  output logic       io_lvl_o
);
  act_st_e    st_q, st_d;
  logic [1:0] code_q;
  logic       accept, off_req;

  assign accept  = wr_ctrl_i && (wcode_i != 2'd0) && gate_i && !flags_any_i;
  assign off_req = wr_ctrl_i && (wcode_i == 2'd0);

  always_comb begin
    st_d          = st_q;
    set_ready_o   = 1'b0;
    set_removed_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_PWR;
      ST_PWR: begin
        if (!gate_i) begin
          st_d          = ST_IDLE;
          set_removed_o = 1'b1;
        end else if (off_req) begin
          st_d = ST_IDLE;
        end else if (supply_ok_i) begin
          st_d        = ST_ACT;
          set_ready_o = 1'b1;
        end
      end
      ST_ACT: begin
        if (!gate_i) begin
          st_d          = ST_D_RST;
          set_removed_o = 1'b1;
        end else if (off_req) begin
          st_d = ST_D_RST;
        end
      end
      ST_D_RST: st_d = ST_D_CLK;
      ST_D_CLK: st_d = ST_D_IO;
      ST_D_IO:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      code_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && accept) code_q <= wcode_i;
      else if (st_d == ST_IDLE)      code_q <= '0;
    end
  end

  logic clk_phase, io_phase;
  assign clk_phase = (st_q == ST_ACT) || (st_q == ST_D_RST);
  assign io_phase  = clk_phase || (st_q == ST_D_CLK);

  assign state_o  = st_q;
  assign vcode_o  = code_q;
  assign vcc_en_o = (st_q != ST_IDLE);
  assign clk_en_o = clk_phase && !ctrl_i.clk_stop;
  assign io_en_o  = io_phase && !ctrl_i.io_dis;
  assign io_lvl_o = io_phase && ctrl_i.io_set;
  assign rst_o    = (st_q == ST_ACT) && (ctrl_i.auto_rst ? rst_auto_i : ctrl_i.rst_sw);
endmodule

// File: rtl/card_act_atr.sv
module card_act_atr
  import card_act_pkg::*;
#(
  parameter int unsigned RST_HOLD = 40000,
  parameter int unsigned ATR_MIN  = 400,
  parameter int unsigned ATR_MAX  = 40000,
  parameter int unsigned MUTE_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic run_i,
  input  logic io_i,
  output logic rst_auto_o,
  output logic set_err_o,
  output logic set_mute_o
);
  localparam int unsigned CNT_TOP = (RST_HOLD > MUTE_CYC) ? RST_HOLD : MUTE_CYC;
  localparam int unsigned CW      = $clog2(CNT_TOP + 1);

  atr_ph_e       ph_q;
  logic [CW-1:0] cnt_q;
  logic          io_q, fall;

  assign fall = io_q && !io_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_HOLD;
      cnt_q      <= '0;
      io_q       <= 1'b1;
      set_err_o  <= 1'b0;
      set_mute_o <= 1'b0;
    end else begin
      io_q       <= io_i;
      set_err_o  <= 1'b0;
      set_mute_o <= 1'b0;
      if (!enable_i) begin
        ph_q  <= PH_HOLD;
        cnt_q <= '0;
      end else if (run_i) begin
        unique case (ph_q)
          PH_HOLD: begin
            if (cnt_q == CW'(RST_HOLD - 1)) begin
              ph_q  <= PH_WATCH;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_WATCH: begin
            if (fall) begin
              set_err_o <= (cnt_q < CW'(ATR_MIN)) || (cnt_q > CW'(ATR_MAX));
              ph_q      <= PH_DONE;
            end else if (cnt_q == CW'(MUTE_CYC - 1)) begin
              set_mute_o <= 1'b1;
              ph_q       <= PH_DONE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rst_auto_o = (ph_q != PH_HOLD);
endmodule

// File: rtl/card_act_seq.sv
module card_act_seq
  import card_act_pkg::*;
#(
  parameter bit          HAS_DETECT = 1'b1,
  parameter int unsigned RST_HOLD   = 40000,
  parameter int unsigned ATR_MIN    = 400,
  parameter int unsigned ATR_MAX    = 40000,
  parameter int unsigned MUTE_CYC   = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       card_present_i,
  input  logic       dcdc_ok_i,
  input  logic       supply_ok_i,
  input  logic       io_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  logic [6:0] wdata_i,
  output logic [6:0] rdata_o,
  output logic       irq_o,
  output logic       vcc_en_o,
  output logic [1:0] vcc_sel_o,
  output logic       clk_en_o,
  output logic       rst_o,
  output logic       io_en_o,
  output logic       io_lvl_o
);
  ctrl_t   ctrl;
  flags_t  flags, set;
  act_st_e state;
  logic    gate, rst_auto, set_ready, set_removed, set_err, set_mute;

  generate
    if (HAS_DETECT) begin : g_detect
      assign gate = card_present_i;
    end else begin : g_shared
      assign gate = dcdc_ok_i;
    end
  endgenerate

  assign set   = '{removed: set_removed, mute: set_mute, atr_err: set_err, ready: set_ready};
  assign irq_o = |flags;

  card_act_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wfield_i (wdata_i[6:2]),
    .vcode_i  (vcc_sel_o),
    .set_i    (set),
    .ctrl_o   (ctrl),
    .flags_o  (flags),
    .rdata_o  (rdata_o)
  );

  card_act_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_ctrl_i     (wr_en_i && addr_i == ADDR_CTRL),
    .wcode_i       (wdata_i[1:0]),
    .gate_i        (gate),
    .supply_ok_i   (supply_ok_i),
    .flags_any_i   (|flags),
    .ctrl_i        (ctrl),
    .rst_auto_i    (rst_auto),
    .state_o       (state),
    .vcode_o       (vcc_sel_o),
    .set_ready_o   (set_ready),
    .set_removed_o (set_removed),
    .vcc_en_o      (vcc_en_o),
    .clk_en_o      (clk_en_o),
    .rst_o         (rst_o),
    .io_en_o       (io_en_o),
    .io_lvl_o      (io_lvl_o)
  );

  card_act_atr #(
    .RST_HOLD (RST_HOLD),
    .ATR_MIN  (ATR_MIN),
    .ATR_MAX  (ATR_MAX),
    .MUTE_CYC (MUTE_CYC)
  ) u_atr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   ((state == ST_ACT) && ctrl.auto_rst),
    .run_i      (!ctrl.clk_stop),
    .io_i       (io_i),
    .rst_auto_o (rst_auto),
    .set_err_o  (set_err),
    .set_mute_o (set_mute)
  );
endmodule

// File: rtl/card_act_seq_chk.sv
module card_act_seq_chk #(
  parameter bit HAS_DETECT = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       card_present_i,
  input logic       dcdc_ok_i,
  input logic       wr_en_i,
  input logic [1:0] addr_i,
  input logic [6:0] wdata_i,
  input logic       irq_o,
  input logic       vcc_en_o,
  input logic [1:0] vcc_sel_o,
  input logic       clk_en_o,
  input logic       rst_o,
  input logic       io_en_o,
  input logic       io_lvl_o
);
  logic gate, wr_ctrl;
  assign gate    = HAS_DETECT ? card_present_i : dcdc_ok_i;
  assign wr_ctrl = wr_en_i && addr_i == 2'd0;

  AST_SEL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_en_o && $past(vcc_en_o) |-> $stable(vcc_sel_o)); // R2
  AST_NO_GATE_NO_POWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl && !vcc_en_o && !gate |=> !vcc_en_o); // R3
  AST_FLAG_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_en_o && irq_o |=> !vcc_en_o); // R3
  AST_QUIET_UNPOWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_en_o |-> !clk_en_o && !rst_o && !io_en_o && !io_lvl_o); // R4
  AST_CLK_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl && wdata_i[3] |=> !clk_en_o); // R5
  AST_MANUAL_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl && !wdata_i[6] && !wdata_i[5] |=> !rst_o); // R6
  AST_OFF_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vcc_en_o) |-> !rst_o && !clk_en_o && !io_en_o && !io_lvl_o); // R11
endmodule

bind card_act_seq card_act_seq_chk #(.HAS_DETECT(HAS_DETECT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .card_present_i (card_present_i),
  .dcdc_ok_i      (dcdc_ok_i),
  .wr_en_i        (wr_en_i),
  .addr_i         (addr_i),
  .wdata_i        (wdata_i),
  .irq_o          (irq_o),
  .vcc_en_o       (vcc_en_o),
  .vcc_sel_o      (vcc_sel_o),
  .clk_en_o       (clk_en_o),
  .rst_o          (rst_o),
  .io_en_o        (io_en_o),
  .io_lvl_o       (io_lvl_o)
);

// File: tb/card_act_seq_tb_top.sv
`timescale 1ns/1ps
module card_act_seq_tb_top;
  localparam int HOLD = 20, AMIN = 8, AMAX = 60, MUTE = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic present = 1'b0, dcdc = 1'b0, sup = 1'b0, io = 1'b1;
  logic wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [6:0] wdata = '0;
  logic [6:0] rdata;
  logic irq, vcc_en, clk_en, rst_c, io_en, io_lvl;
  logic [1:0] vsel;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  card_act_seq #(.HAS_DETECT(1'b1), .RST_HOLD(HOLD), .ATR_MIN(AMIN),
                 .ATR_MAX(AMAX), .MUTE_CYC(MUTE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .card_present_i(present), .dcdc_ok_i(dcdc),
    .supply_ok_i(sup), .io_i(io), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .vcc_en_o(vcc_en),
    .vcc_sel_o(vsel), .clk_en_o(clk_en), .rst_o(rst_c), .io_en_o(io_en),
    .io_lvl_o(io_lvl));

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [6:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [6:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  // expected outputs while active, manual mode
  function automatic logic [3:0] exp_manual(input logic [6:0] c);
    return {!c[3], !c[4], c[2], c[5]};
  endfunction

  // expected status after an auto trial; m < 0 means no edge
  function automatic int exp_atr(input int m);
    if (m < 0) return 4'h5;
    if (m < AMIN || (m > AMAX && m < MUTE)) return 4'h3;
    return 4'h1;
  endfunction

  task automatic auto_trial(input int m);
    logic [6:0] d;
    int low_cnt = 0;
    wr_reg(2'd0, 7'h41);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (rst_c) break;
      if (vcc_en && clk_en) low_cnt++;
    end
    check($sformatf("R7 reset hold (m=%0d)", m), low_cnt, HOLD);
    if (m >= 0) begin
      repeat (m) @(negedge clk);
      io = 1'b0;
    end
    repeat (MUTE + 10) @(negedge clk);
    rd_reg(2'd1, d);
    check($sformatf("R8 R9 status after edge m=%0d", m), int'(d), exp_atr(m));
    wr_reg(2'd0, 7'h40);
    repeat (5) @(negedge clk);
    io = 1'b1;
    check("R11 off after code 0", int'(vcc_en), 0);
  endtask

  initial begin
    logic [6:0] d, c;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1 outputs at reset", int'({vcc_en, vsel, clk_en, rst_c, io_en, io_lvl, irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", int'({vcc_en, vsel, clk_en, rst_c, io_en, io_lvl, irq}), 0);

    wr_reg(2'd0, 7'h01);
    check("R3 no card, write ignored", int'(vcc_en), 0);

    present = 1'b1;
    wr_reg(2'd0, 7'h26);
    check("R2 vcc on", int'(vcc_en), 1);
    check("R2 vcc code", int'(vsel), 2);
    repeat (2) @(negedge clk);
    check("R4 quiet while waiting", int'({clk_en, rst_c, io_en, io_lvl}), 0);
    check("R4 no irq while waiting", int'(irq), 0);
    sup = 1'b1;
    @(negedge clk);
    check("R4 irq on ready", int'(irq), 1);
    rd_reg(2'd1, d);
    check("R10 ready flag read", int'(d), 1);
    check("R10 irq cleared by read", int'(irq), 0);
    rd_reg(2'd1, d);
    check("R10 flags cleared", int'(d), 0);
    check("R5 R6 active after ready", int'({clk_en, io_en, io_lvl, rst_c}), int'(exp_manual(7'h26)));

    for (int i = 0; i < 24; i++) begin
      c = {1'b0, 5'($urandom()) & 5'b01111, 2'b10};
      wr_reg(2'd0, c);
      check($sformatf("R5 R6 random ctrl %0h", c), int'({clk_en, io_en, io_lvl, rst_c}),
            int'(exp_manual(c)));
    end
    check("R2 code held while active", int'(vsel), 2);

    // removal: clk running, io on, rst high
    wr_reg(2'd0, 7'h26);
    present = 1'b0;
    @(negedge clk);
    check("R11 step1 rst low", int'({rst_c, clk_en, io_en, vcc_en}), 4'b0111);
    @(negedge clk);
    check("R11 step2 clk stop", int'({rst_c, clk_en, io_en, io_lvl, vcc_en}), 5'b00111);
    @(negedge clk);
    check("R11 step3 io low", int'({io_en, io_lvl, vcc_en}), 3'b001);
    @(negedge clk);
    check("R11 step4 vcc off", int'(vcc_en), 0);
    present = 1'b1;
    wr_reg(2'd0, 7'h01);
    check("R3 flag set, write ignored", int'(vcc_en), 0);
    rd_reg(2'd1, d);
    check("R11 removed flag", int'(d), 8);
    rd_reg(2'd0, d);
    check("R10 ctrl readback", int'(d[6:2]), int'(7'h01 >> 2));

    auto_trial(AMIN - 5);
    auto_trial(AMIN);
    auto_trial(AMAX);
    auto_trial(AMAX + 1);
    auto_trial(-1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule